// File: doc/BRIEF.md
# Slice Sequencer With Call Stack

This block holds the address of the slice being issued in a machine where each clock step issues one slice, a group of instructions that the parallel execution units run in the same cycle. At most one program-control request arrives with each slice. The request can be a jump, a subroutine call or a return. Any request may be gated by a condition built from the carry and zero flags that the execution units produce. A negate bit inverts the condition.

Calls and returns use a small hardware stack that belongs to the sequencer alone and is kept apart from any data stack. A taken call saves the address of the slice that follows the caller and then moves to the target. A taken return resumes at the saved address. If a call finds the stack full, or a return finds it empty, the request is dropped and the counter moves on by one. A sticky error output is raised and stays set until reset.

Top module: `slice_sequencer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the slice address is 0, the stack is empty and the error output is 0.
- R2: When ctrlOp is 0 (no request), the slice address advances by one per clock and wraps from the all-ones value to 0.
- R3: condSel selects the condition: 0 always true, 1 carry (CF), 2 zero (ZF), 3 equal (ZF), 4 above (not CF and not ZF), 5 above-or-equal (not CF), 6 below (CF), 7 below-or-equal (CF or ZF).
- R4: When condNeg is 1, the selected condition is inverted before it is used. Condition 0 with negation is never true.
- R5: When ctrlOp is 1 (jump) and the condition is true, the next slice address is the target. When the condition is false, the address advances by one.
- R6: When ctrlOp is 2 (call), the condition is true and the stack is not full, the current address plus one is pushed and the next slice address is the target.
- R7: When ctrlOp is 3 (return), the condition is true and the stack is not empty, the most recently pushed address is popped and becomes the next slice address, in last-in first-out order.
- R8: A true call while the stack is full sets the error output. The address advances by one, and the stack contents and depth are left unchanged.
- R9: A true return while the stack is empty sets the error output. The address advances by one and the stack stays empty.
- R10: Once set, the error output stays at 1 until reset.
- R11: The stack holds exactly DEPTH entries (default 8), so DEPTH nested calls succeed and the next one overflows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one slice per rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlOp | input | 2 | Control request: 0 none, 1 jump, 2 call, 3 return |
| condSel | input | 3 | Condition select (see R3) |
| condNeg | input | 1 | Invert the selected condition |
| target | input | ADDR_W | Destination slice address for jump and call |
| carryFlag | input | 1 | Carry flag from the execution units |
| zeroFlag | input | 1 | Zero flag from the execution units |
| sliceAddr | output | ADDR_W | Address of the current slice |
| stackErr | output | 1 | Sticky stack overflow/underflow indication |

## Verification
The assertions assume the following about the inputs:
- Every request input (ctrlOp, condSel, condNeg, target and the two flags) carries a defined value at each rising edge.
- The inputs are stable around that edge.

The bench changes inputs only on the falling clock edge, and every value it drives comes from the legal code space, so both assumptions hold. Random sequences are mixed with forced nested calls. This lets the full and empty stack boundaries be reached on purpose and not only by chance. A reset between random batches clears the sticky error, so each batch also exercises stack traffic that is still free of errors.

// File: rtl/slice_seq_pkg.sv
package slice_seq_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_JUMP = 2'd1,
    OP_CALL = 2'd2,
    OP_RET  = 2'd3
  } ctrlOpE;

  typedef enum logic [2:0] {
    CC_ALWAYS   = 3'd0,
    CC_CARRY    = 3'd1,
    CC_ZERO     = 3'd2,
    CC_EQUAL    = 3'd3,
    CC_ABOVE    = 3'd4,
    CC_ABOVE_EQ = 3'd5,
    CC_BELOW    = 3'd6,
    CC_BELOW_EQ = 3'd7
  } condCodeE;

  // strobes from control to datapath
  typedef struct packed {
    logic loadTarget;
    logic push;
    logic pop;
    logic setErr;
  } seqStrobeT;

endpackage

// File: rtl/slice_seq_ctrl.sv
module slice_seq_ctrl
  import slice_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] ctrlOp,
  input  logic [2:0] condSel,
  input  logic       condNeg,
  input  logic       carryFlag,
  input  logic       zeroFlag,
  input  logic       stackFull,
  input  logic       stackEmpty,
  output seqStrobeT  strb
);

  logic condRaw;
  logic condTrue;

  always_comb begin
    unique case (condCodeE'(condSel))
      CC_ALWAYS:   condRaw = 1'b1;
      CC_CARRY:    condRaw = carryFlag;
      CC_ZERO:     condRaw = zeroFlag;
      CC_EQUAL:    condRaw = zeroFlag;
      CC_ABOVE:    condRaw = ~carryFlag & ~zeroFlag;
      CC_ABOVE_EQ: condRaw = ~carryFlag;
      CC_BELOW:    condRaw = carryFlag;
      CC_BELOW_EQ: condRaw = carryFlag | zeroFlag;
      default:     condRaw = 1'b0;
    endcase
    condTrue = condRaw ^ condNeg;
  end

  always_comb begin
    strb = '0;
    if (condTrue) begin
      unique case (ctrlOpE'(ctrlOp))
        OP_JUMP: strb.loadTarget = 1'b1;
        OP_CALL: begin
          if (stackFull) begin
            strb.setErr = 1'b1;
          end else begin
            strb.push       = 1'b1;
            strb.loadTarget = 1'b1;
          end
        end
        OP_RET: begin
          if (stackEmpty) strb.setErr = 1'b1;
          else            strb.pop    = 1'b1;
        end
        default: ;
      endcase
    end
  end

  AST_FULL_BLOCKS_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    stackFull |-> !strb.push); // R8
  AST_EMPTY_BLOCKS_POP: assert property (@(posedge clk) disable iff (!rstN)
    stackEmpty |-> !strb.pop); // R9
  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlOp == 2'd0) |-> (strb == '0)); // R2

endmodule

// File: rtl/slice_seq_dp.sv
module slice_seq_dp
  import slice_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobeT         strb,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] sliceAddr,
  output logic              stackFull,
  output logic              stackEmpty,
  output logic              stackErr
);

  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [SP_W-1:0]   SP_FULL = SP_W'(DEPTH);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] stackMem [DEPTH];
  logic [SP_W-1:0]   sp;
  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] pcPlusOne;
  logic [ADDR_W-1:0] nextPc;
  logic [IDX_W-1:0]  wrIdx;
  logic [IDX_W-1:0]  rdIdx;
  logic              errQ;

  assign pcPlusOne  = pc + ADDR_ONE;
  assign stackFull  = (sp == SP_FULL);
  assign stackEmpty = (sp == '0);
  assign wrIdx      = IDX_W'(sp);
  assign rdIdx      = IDX_W'(sp - 1'b1);

  always_comb begin
    if (strb.pop)             nextPc = stackMem[rdIdx];
    else if (strb.loadTarget) nextPc = target;
    else                      nextPc = pcPlusOne;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc   <= '0;
      sp   <= '0;
      errQ <= 1'b0;
    end else begin
      pc <= nextPc;
      if (strb.push)      sp <= sp + 1'b1;
      else if (strb.pop)  sp <= sp - 1'b1;
      if (strb.setErr) errQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rstN && strb.push) stackMem[wrIdx] <= pcPlusOne;
  end

  assign sliceAddr = pc;
  assign stackErr  = errQ;

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadTarget && !strb.pop) |=> (sliceAddr == $past(sliceAddr) + ADDR_ONE)); // R2
  AST_TARGET_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadTarget |=> (sliceAddr == $past(target))); // R5
  AST_SP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    sp <= SP_FULL); // R11
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    stackErr |=> stackErr); // R10
  AST_ERR_HOLDS_SP: assert property (@(posedge clk) disable iff (!rstN)
    strb.setErr |=> (sp == $past(sp))); // R8
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |=> (sp == $past(sp) + 1'b1)); // R6
  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |=> (sp == $past(sp) - 1'b1)); // R7

endmodule

// File: rtl/slice_sequencer.sv
module slice_sequencer
  import slice_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        ctrlOp,
  input  logic [2:0]        condSel,
  input  logic              condNeg,
  input  logic [ADDR_W-1:0] target,
  input  logic              carryFlag,
  input  logic              zeroFlag,
  output logic [ADDR_W-1:0] sliceAddr,
  output logic              stackErr
);

  seqStrobeT strb;
  logic      stackFull;
  logic      stackEmpty;

  slice_seq_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlOp     (ctrlOp),
    .condSel    (condSel),
    .condNeg    (condNeg),
    .carryFlag  (carryFlag),
    .zeroFlag   (zeroFlag),
    .stackFull  (stackFull),
    .stackEmpty (stackEmpty),
    .strb       (strb)
  );

  slice_seq_dp #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .target     (target),
    .sliceAddr  (sliceAddr),
    .stackFull  (stackFull),
    .stackEmpty (stackEmpty),
    .stackErr   (stackErr)
  );

  AST_NO_PUSH_AND_POP: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.push && strb.pop)); // R7

endmodule

// File: tb/slice_sequencer_test.sv
`timescale 1ns/1ps
module slice_sequencer_test;

  localparam int AW = 8;
  localparam int DP = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    ctrlOp = 2'd0;
  logic [2:0]    condSel = 3'd0;
  logic          condNeg = 1'b0;
  logic [AW-1:0] target = '0;
  logic          carryFlag = 1'b0;
  logic          zeroFlag = 1'b0;
  logic [AW-1:0] sliceAddr;
  logic          stackErr;

  int vecCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  logic [AW-1:0] mPc;
  logic [AW-1:0] mStk [DP];
  int            mSp;
  logic          mErr;

  always #10 clk = ~clk;

  slice_sequencer #(.ADDR_W(AW), .DEPTH(DP)) uut (
    .clk(clk), .rstN(rstN), .ctrlOp(ctrlOp), .condSel(condSel),
    .condNeg(condNeg), .target(target), .carryFlag(carryFlag),
    .zeroFlag(zeroFlag), .sliceAddr(sliceAddr), .stackErr(stackErr)
  );

  function automatic logic condEval(input logic [2:0] cs, input logic ng,
                                    input logic cf, input logic zf);
    logic r;
    case (cs)
      3'd0: r = 1'b1;
      3'd1: r = cf;
      3'd2: r = zf;
      3'd3: r = zf;
      3'd4: r = !cf && !zf;
      3'd5: r = !cf;
      3'd6: r = cf;
      default: r = cf || zf;
    endcase
    return r ^ ng;
  endfunction

  task automatic compare(input string tag);
    vecCount++;
    if (sliceAddr !== mPc || stackErr !== mErr) begin
      failCount++;
      $display("FAIL %s: addr=%0d err=%0b expected addr=%0d err=%0b",
               tag, sliceAddr, stackErr, mPc, mErr);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    ctrlOp = 2'd0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mPc = '0; mSp = 0; mErr = 1'b0;
    compare("R1");
  endtask

  // inputs are applied at a falling edge; result is checked at the next one
  task automatic step(input logic [1:0] op, input logic [2:0] cs, input logic ng,
                      input logic [AW-1:0] tg, input logic cf, input logic zf,
                      input string tag);
    logic tk;
    ctrlOp = op; condSel = cs; condNeg = ng; target = tg;
    carryFlag = cf; zeroFlag = zf;
    tk = condEval(cs, ng, cf, zf);
    if (tk && op == 2'd1) mPc = tg;
    else if (tk && op == 2'd2) begin
      if (mSp == DP) begin mErr = 1'b1; mPc = mPc + 1'b1; end
      else begin mStk[mSp] = mPc + 1'b1; mSp++; mPc = tg; end
    end else if (tk && op == 2'd3) begin
      if (mSp == 0) begin mErr = 1'b1; mPc = mPc + 1'b1; end
      else begin mSp--; mPc = mStk[mSp]; end
    end else mPc = mPc + 1'b1;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    void'($urandom(32'd20240917));
    mPc = '0; mSp = 0; mErr = 1'b0;
    @(negedge clk);
    compare("R1");
    doReset();
    // R2 plain increment and wrap
    repeat (3) step(2'd0, 3'd0, 1'b0, 8'd0, 1'b0, 1'b0, "R2");
    step(2'd1, 3'd0, 1'b0, 8'd255, 1'b0, 1'b0, "R5");
    step(2'd0, 3'd0, 1'b0, 8'd9, 1'b0, 1'b0, "R2");
    // R3 / R4 each condition against every flag pair
    for (int cs = 0; cs < 8; cs++)
      for (int fl = 0; fl < 4; fl++) begin
        step(2'd1, 3'(cs), 1'b0, 8'(16 + cs * 4 + fl), fl[1], fl[0], "R3");
        step(2'd1, 3'(cs), 1'b1, 8'(100 + cs * 4 + fl), fl[1], fl[0], "R4");
      end
    // R9 underflow on a fresh stack, R10 stickiness
    doReset();
    step(2'd3, 3'd0, 1'b0, 8'd0, 1'b0, 1'b0, "R9");
    repeat (3) step(2'd0, 3'd0, 1'b0, 8'd0, 1'b0, 1'b0, "R10");
    // R6 / R11 nesting to full depth, R8 overflow, R7 unwind
    doReset();
    for (int i = 0; i < DP; i++) begin
      step(2'd0, 3'd0, 1'b0, 8'd0, 1'b0, 1'b0, "R2");
      step(2'd2, 3'd0, 1'b0, 8'(40 + i * 20), 1'b0, 1'b0, "R6");
    end
    step(2'd2, 3'd0, 1'b0, 8'd7, 1'b0, 1'b0, "R8");
    step(2'd2, 3'd1, 1'b0, 8'd7, 1'b0, 1'b0, "R5");
    for (int i = 0; i < DP; i++)
      step(2'd3, 3'd0, 1'b0, 8'd0, 1'b0, 1'b0, "R7");
    step(2'd3, 3'd0, 1'b0, 8'd0, 1'b0, 1'b0, "R9");
    step(2'd0, 3'd0, 1'b0, 8'd0, 1'b0, 1'b0, "R10");
    doReset();
    // constrained random batches, reset between them
    for (int b = 0; b < 6; b++) begin
      for (int n = 0; n < 400; n++) begin
        logic [1:0] op;
        int sel;
        sel = $urandom_range(0, 9);
        op = (sel < 3) ? 2'd0 : (sel < 5) ? 2'd1 : (sel < 8) ? 2'd2 : 2'd3;
        step(op, 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
             8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)), "R5R6R7");
      end
      doReset();
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

endmodule